// File: doc/BRIEF.md
# Programmable Dual-Ratio Clock Divider

This block runs on one fast reference clock, which stands in for the output of a frequency synthesizer. From it, the block derives two slower rates: a core rate and a system rate. Each rate leaves the block as an enable pulse that is one reference cycle wide. Both ratios sit in one six-bit divisor word. Software may rewrite that word at any moment without stopping either divider.

The core ratio is a power of two, chosen by a two-bit code. The system ratio is a linear count from 1 to 15. A new ratio waits for the running period to reach its terminal count. Because of this, no output period is ever cut short.

An external clock pin can carry one of two sources: a square wave at the system rate, or the reference clock passed straight through. The pin is modelled as a data value plus an output enable. It stays undriven from reset until its enable is set.

Top module: `dual_ratio_clkgen`

## Requirements
- R1: While `rst_n` is low, and after it is released, `core_tick`, `sys_tick`, `ext_clk_oe` and `ext_clk` are low during reset. After release, the active ratios are core divide-by-1 and system divide-by-8.
- R2: When `div_wr` is high on a rising edge, the block captures the divisor word. Bits [3:0] are the system ratio and bits [5:4] are the core code.
- R3: For a system ratio N from 1 to 15, `sys_tick` is high for exactly one cycle out of every N reference cycles.
- R4: A system ratio of 0 behaves as divide-by-1, so `sys_tick` is high on every cycle.
- R5: The core codes 0, 1, 2 and 3 give `core_tick` periods of 1, 2, 4 and 8 reference cycles, with a pulse one cycle wide.
- R6: A new ratio takes effect only after the running period ends. The spacing between ticks across a change is always either the old period or the new one, and the period in progress when the write lands finishes at the old length.
- R7: `ext_clk_oe` follows `pin_en` one cycle later. While `ext_clk_oe` is low, `ext_clk` is low.
- R8: With `pin_src` low, the pin carries a system-rate square wave for N ≥ 2. The wave is high for the first ceil(N/2) cycles of each period, counted from the cycle in which `sys_tick` is high. For N = 1 the pin carries the reference clock.
- R9: With `pin_src` high, the pin carries the reference clock itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_wr | input | 1 | Write strobe for the divisor word |
| div_wdata | input | 6 | Divisor word: [5:4] core code, [3:0] system ratio |
| pin_en | input | 1 | Enable request for the external clock pin |
| pin_src | input | 1 | Pin source: 0 = system wave, 1 = reference clock |
| core_tick | output | 1 | Core-rate enable pulse |
| sys_tick | output | 1 | System-rate enable pulse |
| ext_clk | output | 1 | External pin data value |
| ext_clk_oe | output | 1 | External pin output enable |

## Verification
The bench writes a ratio just after a system tick. It then checks that the period already running completes at full length before the new spacing starts. A design that switched ratio at once would produce a shortened runt period here, and one that never reloaded would keep the old spacing.

A system field of zero is driven deliberately. A design that used the value literally would stall the output or wrap to a 16-cycle period.

The pin is probed in both clock phases. This shows whether divide-by-1 and the reference source really pass the clock through, and whether a disabled pin is held low. Finally, a reset in the middle of a run must bring back the default ratios and a quiet pin.

// File: rtl/clkdiv_pkg.sv
// Shared widths, divisor word layout and ratio decoding for the dual-ratio
// clock divider. Assumes system ratios fit the shared counter width.
package clkdiv_pkg;
    localparam int SYS_W  = 4;                  // system ratio field width
    localparam int CORE_W = 2;                  // core code field width
    localparam int CNT_W  = 4;                  // divider counter width
    localparam int WORD_W = SYS_W + CORE_W;     // divisor word width

    // Divisor word: core code in the upper bits, system ratio in the lower bits.
    typedef struct packed {
        logic [CORE_W-1:0] core_code;
        logic [SYS_W-1:0]  sys_ratio;
    } div_word_t;

    // Terminal count for a system ratio; zero is treated as divide-by-1.
    function automatic logic [CNT_W-1:0] sys_last(input logic [SYS_W-1:0] r);
        logic [CNT_W-1:0] v;
        v = CNT_W'(r);
        return (v == '0) ? '0 : v - CNT_W'(1);
    endfunction

    // Terminal count for a power-of-two core code.
    function automatic logic [CNT_W-1:0] core_last(input logic [CORE_W-1:0] c);
        int v;
        v = (1 << c) - 1;
        return v[CNT_W-1:0];
    endfunction
endpackage

// File: rtl/div_register.sv
// Holds the programmed divisor word and presents decoded terminal counts.
// Assumes writes may arrive on any cycle; the dividers decide when to use them.
module div_register
    import clkdiv_pkg::*;
#(
    parameter int SYS_RST_RATIO = 8,
    parameter int CORE_RST_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  core_last_nxt,
    output logic [CNT_W-1:0]  sys_last_nxt
);
    localparam div_word_t RST_WORD = '{core_code: CORE_W'(CORE_RST_CODE),
                                       sys_ratio: SYS_W'(SYS_RST_RATIO)};

    div_word_t word_q;

    // Capture the divisor word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  word_q <= RST_WORD;
        else if (wr) word_q <= div_word_t'(wdata);
    end

    // Decode both fields into terminal counts.
    always_comb begin
        core_last_nxt = core_last(word_q.core_code);
        sys_last_nxt  = sys_last(word_q.sys_ratio);
    end
endmodule

// File: rtl/ratio_counter.sv
// Free-running divider producing a one-cycle tick every (last+1) cycles.
// A new terminal count is adopted only when the current one is reached,
// so a ratio change never shortens the period in progress.
module ratio_counter
    import clkdiv_pkg::*;
#(
    parameter int W = CNT_W,
    parameter logic [W-1:0] LAST_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] last_nxt,
    output logic         tick,
    output logic [W-1:0] count,
    output logic [W-1:0] last_cur
);
    localparam logic [W-1:0] STEP = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] last_q;
    logic         tick_q;

    // Count up to the terminal value, then wrap, reload the ratio and tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= LAST_RST;
            tick_q <= 1'b0;
        end else if (cnt_q == last_q) begin
            cnt_q  <= '0;
            last_q <= last_nxt;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + STEP;
            tick_q <= 1'b0;
        end
    end

    assign tick     = tick_q;
    assign count    = cnt_q;
    assign last_cur = last_q;

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_q); // R3

    AST_RELOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(last_q) |-> ($past(cnt_q) == $past(last_q))); // R6
endmodule

// File: rtl/extclk_select.sv
// Drives the external clock pin model: registered enable and source select,
// a system-rate square wave built from the system counter, or the reference
// clock passed through. Assumes the pin is modelled as value plus enable.
module extclk_select
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_en,
    input  logic             pin_src,
    input  logic [CNT_W-1:0] sys_count,
    input  logic [CNT_W-1:0] sys_last_cur,
    output logic             ext_clk,
    output logic             ext_clk_oe
);
    localparam logic [CNT_W:0] TWO = (CNT_W+1)'(2);

    logic           en_q;
    logic           src_q;
    logic [CNT_W:0] half;
    logic           sys_wave;

    // Register the pin controls; reset leaves the pin undriven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            src_q <= 1'b0;
        end else begin
            en_q  <= pin_en;
            src_q <= pin_src;
        end
    end

    // Build the system wave: high for the first ceil(N/2) counts of a period.
    always_comb begin
        half     = ({1'b0, sys_last_cur} + TWO) >> 1;
        sys_wave = (sys_last_cur == '0) ? clk : ({1'b0, sys_count} < half);
    end

    // Select the pin source and hold it low while disabled.
    always_comb begin
        ext_clk = en_q ? (src_q ? clk : sys_wave) : 1'b0;
    end
    assign ext_clk_oe = en_q;

    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_clk_oe |-> !ext_clk); // R7

    AST_OE_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pin_en |=> ext_clk_oe); // R7
endmodule

// File: rtl/dual_ratio_clkgen.sv
// Top of the dual-ratio clock divider. One divisor word sets a power-of-two
// core ratio and a linear system ratio; each drives its own counter. The
// external pin model selects the system wave or the reference clock.
module dual_ratio_clkgen
    import clkdiv_pkg::*;
#(
    parameter int SYS_RST_RATIO = 8,
    parameter int CORE_RST_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_wr,
    input  logic [WORD_W-1:0] div_wdata,
    input  logic              pin_en,
    input  logic              pin_src,
    output logic              core_tick,
    output logic              sys_tick,
    output logic              ext_clk,
    output logic              ext_clk_oe
);
    localparam logic [CNT_W-1:0] SYS_LAST_RST  = sys_last(SYS_W'(SYS_RST_RATIO));
    localparam logic [CNT_W-1:0] CORE_LAST_RST = core_last(CORE_W'(CORE_RST_CODE));

    logic [CNT_W-1:0] core_last_nxt, sys_last_nxt;
    logic [CNT_W-1:0] core_count, core_last_cur;
    logic [CNT_W-1:0] sys_count, sys_last_cur;

    div_register #(
        .SYS_RST_RATIO (SYS_RST_RATIO),
        .CORE_RST_CODE (CORE_RST_CODE)
    ) u_reg (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr            (div_wr),
        .wdata         (div_wdata),
        .core_last_nxt (core_last_nxt),
        .sys_last_nxt  (sys_last_nxt)
    );

    ratio_counter #(.W(CNT_W), .LAST_RST(CORE_LAST_RST)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .last_nxt (core_last_nxt),
        .tick     (core_tick),
        .count    (core_count),
        .last_cur (core_last_cur)
    );

    ratio_counter #(.W(CNT_W), .LAST_RST(SYS_LAST_RST)) u_sys (
        .clk      (clk),
        .rst_n    (rst_n),
        .last_nxt (sys_last_nxt),
        .tick     (sys_tick),
        .count    (sys_count),
        .last_cur (sys_last_cur)
    );

    extclk_select u_pin (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_en       (pin_en),
        .pin_src      (pin_src),
        .sys_count    (sys_count),
        .sys_last_cur (sys_last_cur),
        .ext_clk      (ext_clk),
        .ext_clk_oe   (ext_clk_oe)
    );

    AST_ZERO_RATIO_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_last_cur == '0) |=> sys_tick); // R4

    AST_CORE_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({1'b0, core_last_cur} + 5'd1) == 1); // R5
endmodule

// File: tb/sim_dual_ratio_clkgen.sv
`timescale 1ns/1ps
module sim_dual_ratio_clkgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_wr = 1'b0;
    logic [5:0] div_wdata = '0;
    logic       pin_en = 1'b0;
    logic       pin_src = 1'b0;
    logic       core_tick, sys_tick, ext_clk, ext_clk_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_ratio_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
        .pin_en(pin_en), .pin_src(pin_src), .core_tick(core_tick),
        .sys_tick(sys_tick), .ext_clk(ext_clk), .ext_clk_oe(ext_clk_oe)
    );

    // {divisor word, expected core period, expected system period}
    localparam int VEC [7][3] = '{
        '{'h02, 1, 2},
        '{'h16, 2, 6},
        '{'h2A, 4, 10},
        '{'h31, 8, 1},
        '{'h0F, 1, 15},
        '{'h20, 4, 1},
        '{'h13, 2, 3}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_div(input logic [5:0] d);
        @(negedge clk);
        div_wr = 1'b1;
        div_wdata = d;
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    // Count tick spacings that differ from the expected periods.
    task automatic measure(input int ncyc, input int exp_core, input int exp_sys,
                           output int bad_core, output int bad_sys,
                           output int n_core, output int n_sys);
        int lc = -1;
        int ls = -1;
        bad_core = 0; bad_sys = 0; n_core = 0; n_sys = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (core_tick) begin
                if (lc >= 0 && c - lc != exp_core) bad_core++;
                lc = c; n_core++;
            end
            if (sys_tick) begin
                if (ls >= 0 && c - ls != exp_sys) bad_sys++;
                ls = c; n_sys++;
            end
        end
    endtask

    // Compare the pin with the square wave expected for system period n.
    task automatic check_wave(input int n, input string req);
        int k = -1;
        int bad = 0;
        for (int c = 0; c < 4 * n + 20; c++) begin
            @(negedge clk);
            if (sys_tick) k = 0;
            else if (k >= 0) k++;
            if (k >= 0 && ext_clk != (k < (n + 1) / 2)) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    // Check the pin follows the reference clock in both phases.
    task automatic check_follow(input string req);
        int bad = 0;
        for (int c = 0; c < 8; c++) begin
            @(posedge clk); #2;
            if (ext_clk !== 1'b1) bad++;
            @(negedge clk); #2;
            if (ext_clk !== 1'b0) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int bc, bs, nc, ns;
        int t0, g1, g2, g3, cyc;

        // R1: reset state
        repeat (5) @(negedge clk);
        check(!core_tick && !sys_tick, "R1 ticks in reset", int'(core_tick | sys_tick), 0);
        check(!ext_clk_oe && !ext_clk, "R1 pin in reset", int'(ext_clk_oe | ext_clk), 0);
        rst_n = 1'b1;
        measure(60, 1, 8, bc, bs, nc, ns);
        check(bc == 0 && nc >= 3, "R1 core default period", bc, 0);
        check(bs == 0 && ns >= 3, "R1 system default period", bs, 0);

        // R2 R3 R4 R5: vector table
        for (int i = 0; i < 7; i++) begin
            write_div(6'(VEC[i][0]));
            repeat (40) @(negedge clk);
            measure(130, VEC[i][1], VEC[i][2], bc, bs, nc, ns);
            check(bc == 0 && nc >= 3, "R5 R2 core period", bc, 0);
            if ((VEC[i][0] & 'hF) == 0)
                check(bs == 0 && ns >= 3, "R4 zero system ratio", bs, 0);
            else
                check(bs == 0 && ns >= 3, "R3 R2 system period", bs, 0);
        end

        // R6: change from 15 to 2 just after a tick
        write_div(6'h0F);
        repeat (40) @(negedge clk);
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!sys_tick && cyc < 40);
        t0 = cyc;
        div_wr = 1'b1; div_wdata = 6'h02;
        @(negedge clk); cyc++; div_wr = 1'b0;
        while (!sys_tick && cyc < 100) begin @(negedge clk); cyc++; end
        g1 = cyc - t0; t0 = cyc;
        do begin @(negedge clk); cyc++; end while (!sys_tick && cyc < 120);
        g2 = cyc - t0; t0 = cyc;
        do begin @(negedge clk); cyc++; end while (!sys_tick && cyc < 140);
        g3 = cyc - t0;
        check(g1 == 15, "R6 running period completes", g1, 15);
        check(g2 == 2, "R6 new period after wrap", g2, 2);
        check(g3 == 2, "R6 new period held", g3, 2);

        // R7: enable pin
        @(negedge clk); pin_en = 1'b1; pin_src = 1'b0;
        @(negedge clk);
        check(ext_clk_oe, "R7 output enable follows request", int'(ext_clk_oe), 1);

        // R8: system wave, even, odd, and divide-by-1
        write_div(6'h04);
        repeat (30) @(negedge clk);
        check_wave(4, "R8 wave N=4");
        write_div(6'h03);
        repeat (30) @(negedge clk);
        check_wave(3, "R8 wave N=3");
        write_div(6'h01);
        repeat (30) @(negedge clk);
        check_follow("R8 wave N=1 follows reference");

        // R9: reference source
        write_div(6'h05);
        @(negedge clk); pin_src = 1'b1;
        repeat (30) @(negedge clk);
        check_follow("R9 reference source");

        // R7: disable pin
        @(negedge clk); pin_en = 1'b0;
        @(negedge clk);
        check(!ext_clk_oe, "R7 output enable dropped", int'(ext_clk_oe), 0);
        @(posedge clk); #2;
        check(!ext_clk, "R7 pin low while disabled", int'(ext_clk), 0);

        // R1: reset mid-run
        @(negedge clk); pin_en = 1'b1; pin_src = 1'b0;
        write_div(6'h36);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!core_tick && !sys_tick && !ext_clk_oe, "R1 mid-run reset quiet",
              int'(core_tick | sys_tick | ext_clk_oe), 0);
        pin_en = 1'b0;
        rst_n = 1'b1;
        measure(60, 1, 8, bc, bs, nc, ns);
        check(bc == 0 && bs == 0 && nc >= 3 && ns >= 3, "R1 defaults after reset",
              bc + bs, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule